// File: doc/BRIEF.md
# Serial Channel FIFO Pair with Threshold Interrupts

This block holds the receive and transmit byte FIFOs of one serial channel and turns their fill levels into interrupt status. The receiver side pushes incoming bytes and the host pops them. The host pushes bytes for transmission and the serializer pops them. Each FIFO shows its oldest entry on its read data port whenever it is not empty.

A two-bit receive code and a two-bit transmit code select the level at which receive-ready and transmit-ready assert. The receive code is built from two separate mode bits. The transmit code is a single two-bit field. The `DEPTH` parameter (8 or 16) picks the FIFO size and the matching threshold table.

Four status bits form the raw status: transmit-ready, receive-ready, receive overrun and transmit-empty. A write-only mask is held in an internal shadow register. The block outputs the raw status, the raw status ANDed with that shadow, and one interrupt line that is high when any masked bit is set.

Each FIFO tracks its occupancy with a three-state machine. The states are `OCC_EMPTY`, `OCC_PART` and `OCC_FULL`. The transitions are:
- empty to part on an accepted push;
- part to empty when the next count is zero;
- part to full when the next count equals `DEPTH`;
- full to part on a pop without a push.

All other cases hold the current state. The overrun bit has its own machine:
- `OVR_IDLE` moves to `OVR_LATCHED` on a dropped receive push;
- `OVR_LATCHED` moves back to `OVR_IDLE` on a clear strobe, unless a new drop happens in the same cycle.

Top module: `chan_fifo_irq`

## Requirements
- R1: After reset both FIFOs are empty, the mask shadow is 0 and overrun is clear. So `stat_raw` = 4'b1001, `stat_masked` = 0 and `irq` = 0.
- R2: With DEPTH=8, the receive code is {`rx_lvl_hi`, `rx_lvl_lo`}. Codes 0, 1, 2 and 3 need 1, 3, 6 and 8 held bytes. `stat_raw[1]` is high exactly while the count is at or above the selected level.
- R3: With DEPTH=16, receive codes 0, 1, 2 and 3 need 1, 6, 12 and 16 held bytes. The rule is otherwise as in R2.
- R4: With DEPTH=8, `stat_raw[0]` is high when the free slots of the transmit FIFO reach the level set by `tx_lvl`. Code 0 needs 8 free slots (fully empty), code 1 needs 4, code 2 needs 6 and code 3 needs 1.
- R5: With DEPTH=16, transmit codes 0, 1, 2 and 3 need 16, 6, 12 and 1 free slots.
- R6: Both FIFOs keep first-in first-out order. The oldest byte is visible on the read data port while the FIFO is non-empty, and a pop advances to the next byte.
- R7: A receive push into a full FIFO without a pop is discarded and sets `stat_raw[2]`. That bit stays set until `ovr_clr`, and a drop wins over a clear in the same cycle. A push into the full transmit FIFO is discarded silently. A push with a pop on a full FIFO is accepted.
- R8: A pop from an empty FIFO changes nothing. A push together with a pop on an empty FIFO stores the byte.
- R9: `stat_raw[3]` is high exactly when the transmit FIFO holds no bytes.
- R10: `stat_masked` equals `stat_raw` ANDed with the last value written by `mask_we`. A new mask applies from the clock edge that writes it.
- R11: `irq` is the OR of all `stat_masked` bits.
- R12: Status reflects a push or pop at the same clock edge that registers it. A change of mode bits affects the ready bits with no clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_push | input | 1 | Receive FIFO write strobe |
| rx_wdata | input | 8 | Receive byte to store |
| rx_pop | input | 1 | Receive FIFO read strobe |
| rx_rdata | output | 8 | Oldest receive byte |
| tx_push | input | 1 | Transmit FIFO write strobe |
| tx_wdata | input | 8 | Transmit byte to store |
| tx_pop | input | 1 | Transmit FIFO read strobe |
| tx_rdata | output | 8 | Oldest transmit byte |
| rx_lvl_hi | input | 1 | High bit of receive threshold code |
| rx_lvl_lo | input | 1 | Low bit of receive threshold code |
| tx_lvl | input | 2 | Transmit threshold code |
| mask_we | input | 1 | Mask write strobe |
| mask_wdata | input | 4 | Mask value to store |
| ovr_clr | input | 1 | Clears the sticky overrun bit |
| stat_raw | output | 4 | Raw status: [0] tx ready, [1] rx ready, [2] overrun, [3] tx empty |
| stat_masked | output | 4 | Raw status ANDed with mask shadow |
| irq | output | 1 | Interrupt, OR of masked status |

## Verification
Every stored result appears at the rising edge that registers the strobe, with no added cycle. This covers FIFO contents, read data, overrun, the mask shadow and all status bits. Mode bits act combinationally. The bench drives strobes after a falling edge and steps one rising edge. At the next falling edge it compares all outputs of both depth variants against a queue-based model that has advanced by that same edge. After a mode change alone, it compares once more a nanosecond later, with no edge in between.

// File: rtl/chan_fifo_pkg.sv
package chan_fifo_pkg;

    localparam int STAT_W     = 4;
    localparam int ST_TXRDY   = 0;
    localparam int ST_RXRDY   = 1;
    localparam int ST_RXOVR   = 2;
    localparam int ST_TXEMPTY = 3;

    typedef enum logic [1:0] {
        OCC_EMPTY,
        OCC_PART,
        OCC_FULL
    } occ_state_e;

    typedef enum logic {
        OVR_IDLE,
        OVR_LATCHED
    } ovr_state_e;

endpackage

// File: rtl/chan_fifo_buf.sv
module chan_fifo_buf
    import chan_fifo_pkg::*;
#(
    parameter  int DEPTH = 8,
    parameter  int DW    = 8,
    localparam int AW    = $clog2(DEPTH),
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] wdata,
    input  logic          pop,
    output logic [DW-1:0] rdata,
    output logic [CW-1:0] count,
    output occ_state_e    occ
);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_d;
    occ_state_e    st_q;
    occ_state_e    st_d;
    logic          pop_ok;
    logic          push_ok;

    // a pop needs data present; a push needs space or a same-cycle pop
    assign pop_ok  = pop && (st_q != OCC_EMPTY);
    assign push_ok = push && ((st_q != OCC_FULL) || pop_ok);

    always_comb begin
        cnt_d = cnt_q;
        if (push_ok && !pop_ok) begin
            cnt_d = cnt_q + 1'b1;
        end else if (pop_ok && !push_ok) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            OCC_EMPTY: st_d = push_ok ? OCC_PART : OCC_EMPTY;
            OCC_PART: begin
                if (cnt_d == '0) begin
                    st_d = OCC_EMPTY;
                end else if (cnt_d == CW'(DEPTH)) begin
                    st_d = OCC_FULL;
                end else begin
                    st_d = OCC_PART;
                end
            end
            OCC_FULL:  st_d = (pop_ok && !push_ok) ? OCC_PART : OCC_FULL;
            default:   st_d = OCC_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= OCC_EMPTY;
            cnt_q  <= '0;
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            if (push_ok) begin
                wr_ptr <= wr_ptr + 1'b1;
            end
            if (pop_ok) begin
                rd_ptr <= rd_ptr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[wr_ptr] <= wdata;
        end
    end

    always_comb begin
        occ   = st_q;
        count = cnt_q;
        rdata = mem[rd_ptr];
    end

endmodule

// File: rtl/chan_fifo_thresh.sv
module chan_fifo_thresh #(
    parameter  int DEPTH = 8,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic [1:0]    rx_code,
    input  logic [1:0]    tx_code,
    input  logic [CW-1:0] rx_cnt,
    input  logic [CW-1:0] tx_cnt,
    output logic          rx_ready,
    output logic          tx_ready
);

    logic [CW-1:0] rx_need;
    logic [CW-1:0] tx_need;
    logic [CW-1:0] tx_free;

    generate
        if (DEPTH == 16) begin : g_d16
            always_comb begin
                unique case (rx_code)
                    2'b00:   rx_need = CW'(1);
                    2'b01:   rx_need = CW'(6);
                    2'b10:   rx_need = CW'(12);
                    default: rx_need = CW'(16);
                endcase
                unique case (tx_code)
                    2'b00:   tx_need = CW'(16);
                    2'b01:   tx_need = CW'(6);
                    2'b10:   tx_need = CW'(12);
                    default: tx_need = CW'(1);
                endcase
            end
        end else begin : g_d8
            always_comb begin
                unique case (rx_code)
                    2'b00:   rx_need = CW'(1);
                    2'b01:   rx_need = CW'(3);
                    2'b10:   rx_need = CW'(6);
                    default: rx_need = CW'(8);
                endcase
                unique case (tx_code)
                    2'b00:   tx_need = CW'(8);
                    2'b01:   tx_need = CW'(4);
                    2'b10:   tx_need = CW'(6);
                    default: tx_need = CW'(1);
                endcase
            end
        end
    endgenerate

    assign tx_free  = CW'(DEPTH) - tx_cnt;
    assign rx_ready = (rx_cnt >= rx_need);
    assign tx_ready = (tx_free >= tx_need);

endmodule

// File: rtl/chan_fifo_stat.sv
module chan_fifo_stat
    import chan_fifo_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ovr_evt,
    input  logic              ovr_clr,
    input  logic              mask_we,
    input  logic [STAT_W-1:0] mask_wdata,
    input  logic              rx_ready,
    input  logic              tx_ready,
    input  logic              tx_empty,
    output logic [STAT_W-1:0] stat_raw,
    output logic [STAT_W-1:0] stat_masked,
    output logic              irq
);

    ovr_state_e        ovr_q;
    ovr_state_e        ovr_d;
    logic [STAT_W-1:0] mask_q;

    always_comb begin
        ovr_d = ovr_q;
        unique case (ovr_q)
            OVR_IDLE:    ovr_d = ovr_evt ? OVR_LATCHED : OVR_IDLE;
            OVR_LATCHED: ovr_d = (ovr_clr && !ovr_evt) ? OVR_IDLE : OVR_LATCHED;
            default:     ovr_d = OVR_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovr_q  <= OVR_IDLE;
            mask_q <= '0;
        end else begin
            ovr_q <= ovr_d;
            if (mask_we) begin
                mask_q <= mask_wdata;
            end
        end
    end

    always_comb begin
        stat_raw             = '0;
        stat_raw[ST_TXRDY]   = tx_ready;
        stat_raw[ST_RXRDY]   = rx_ready;
        stat_raw[ST_RXOVR]   = (ovr_q == OVR_LATCHED);
        stat_raw[ST_TXEMPTY] = tx_empty;
        stat_masked          = stat_raw & mask_q;
        irq                  = |stat_masked;
    end

endmodule

// File: rtl/chan_fifo_irq.sv
module chan_fifo_irq
    import chan_fifo_pkg::*;
#(
    parameter  int DEPTH = 8,
    parameter  int DW    = 8,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_push,
    input  logic [DW-1:0]     rx_wdata,
    input  logic              rx_pop,
    output logic [DW-1:0]     rx_rdata,
    input  logic              tx_push,
    input  logic [DW-1:0]     tx_wdata,
    input  logic              tx_pop,
    output logic [DW-1:0]     tx_rdata,
    input  logic              rx_lvl_hi,
    input  logic              rx_lvl_lo,
    input  logic [1:0]        tx_lvl,
    input  logic              mask_we,
    input  logic [STAT_W-1:0] mask_wdata,
    input  logic              ovr_clr,
    output logic [STAT_W-1:0] stat_raw,
    output logic [STAT_W-1:0] stat_masked,
    output logic              irq
);

    logic [CW-1:0] rx_cnt;
    logic [CW-1:0] tx_cnt;
    occ_state_e    rx_occ;
    occ_state_e    tx_occ;
    logic          rx_ready;
    logic          tx_ready;
    logic          ovr_evt;

    chan_fifo_buf #(.DEPTH(DEPTH), .DW(DW)) u_rx_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (rx_push),
        .wdata (rx_wdata),
        .pop   (rx_pop),
        .rdata (rx_rdata),
        .count (rx_cnt),
        .occ   (rx_occ)
    );

    chan_fifo_buf #(.DEPTH(DEPTH), .DW(DW)) u_tx_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (tx_push),
        .wdata (tx_wdata),
        .pop   (tx_pop),
        .rdata (tx_rdata),
        .count (tx_cnt),
        .occ   (tx_occ)
    );

    chan_fifo_thresh #(.DEPTH(DEPTH)) u_thresh (
        .rx_code  ({rx_lvl_hi, rx_lvl_lo}),
        .tx_code  (tx_lvl),
        .rx_cnt   (rx_cnt),
        .tx_cnt   (tx_cnt),
        .rx_ready (rx_ready),
        .tx_ready (tx_ready)
    );

    // a push is dropped only when full and no pop frees a slot
    assign ovr_evt = rx_push && !rx_pop && (rx_occ == OCC_FULL);

    chan_fifo_stat u_stat (
        .clk         (clk),
        .rst_n       (rst_n),
        .ovr_evt     (ovr_evt),
        .ovr_clr     (ovr_clr),
        .mask_we     (mask_we),
        .mask_wdata  (mask_wdata),
        .rx_ready    (rx_ready),
        .tx_ready    (tx_ready),
        .tx_empty    (tx_occ == OCC_EMPTY),
        .stat_raw    (stat_raw),
        .stat_masked (stat_masked),
        .irq         (irq)
    );

endmodule

// File: rtl/chan_fifo_irq_chk.sv
module chan_fifo_irq_chk #(
    parameter  int DEPTH = 8,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rx_push,
    input logic          rx_pop,
    input logic          ovr_clr,
    input logic          mask_we,
    input logic [3:0]    mask_wdata,
    input logic [3:0]    stat_raw,
    input logic [3:0]    stat_masked,
    input logic          irq,
    input logic [CW-1:0] rx_cnt,
    input logic [CW-1:0] tx_cnt
);

    logic [3:0] shadow;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shadow <= '0;
        end else if (mask_we) begin
            shadow <= mask_wdata;
        end
    end

    // R10
    masked_and_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_masked == (stat_raw & shadow));

    // R11
    irq_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (stat_masked != 4'b0000));

    // R7
    ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && !rx_pop && rx_cnt == CW'(DEPTH)) |=> stat_raw[2]);

    // R7
    ovr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_raw[2] && !ovr_clr) |=> stat_raw[2]);

    // R8
    pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_pop && !rx_push && rx_cnt == '0) |=> (rx_cnt == '0));

    // R2
    rx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_cnt <= CW'(DEPTH));

    // R9
    tx_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_raw[3] == (tx_cnt == '0));

endmodule

bind chan_fifo_irq chan_fifo_irq_chk #(.DEPTH(DEPTH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_push     (rx_push),
    .rx_pop      (rx_pop),
    .ovr_clr     (ovr_clr),
    .mask_we     (mask_we),
    .mask_wdata  (mask_wdata),
    .stat_raw    (stat_raw),
    .stat_masked (stat_masked),
    .irq         (irq),
    .rx_cnt      (rx_cnt),
    .tx_cnt      (tx_cnt)
);

// File: tb/chan_fifo_irq_test.sv
module chan_fifo_ref #(
    parameter int DEPTH = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_push,
    input  logic [7:0] rx_wdata,
    input  logic       rx_pop,
    input  logic       tx_push,
    input  logic [7:0] tx_wdata,
    input  logic       tx_pop,
    input  logic       rx_lvl_hi,
    input  logic       rx_lvl_lo,
    input  logic [1:0] tx_lvl,
    input  logic       mask_we,
    input  logic [3:0] mask_wdata,
    input  logic       ovr_clr,
    output logic [3:0] e_raw,
    output logic [3:0] e_masked,
    output logic       e_irq,
    output int         e_rx_n,
    output int         e_tx_n,
    output logic [7:0] e_rx_head,
    output logic [7:0] e_tx_head
);

    logic [7:0] rxq[$];
    logic [7:0] txq[$];
    logic       ovr;
    logic [3:0] msk;

    function automatic int rx_need(input int d, input logic [1:0] c);
        if (d == 16) return (c == 2'd0) ? 1 : (c == 2'd1) ? 6 : (c == 2'd2) ? 12 : 16;
        return (c == 2'd0) ? 1 : (c == 2'd1) ? 3 : (c == 2'd2) ? 6 : 8;
    endfunction

    function automatic int tx_need(input int d, input logic [1:0] c);
        if (d == 16) return (c == 2'd0) ? 16 : (c == 2'd1) ? 6 : (c == 2'd2) ? 12 : 1;
        return (c == 2'd0) ? 8 : (c == 2'd1) ? 4 : (c == 2'd2) ? 6 : 1;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rxq.delete();
            txq.delete();
            ovr = 1'b0;
            msk = 4'h0;
        end else begin : upd
            bit rp;
            bit tp;
            rp = rx_pop && (rxq.size() != 0);
            tp = tx_pop && (txq.size() != 0);
            if (rp) void'(rxq.pop_front());
            if (tp) void'(txq.pop_front());
            if (ovr_clr) ovr = 1'b0;
            if (rx_push) begin
                if (rxq.size() < DEPTH) rxq.push_back(rx_wdata);
                else ovr = 1'b1;
            end
            if (tx_push && txq.size() < DEPTH) txq.push_back(tx_wdata);
            if (mask_we) msk = mask_wdata;
        end
        e_rx_n    = rxq.size();
        e_tx_n    = txq.size();
        e_rx_head = (rxq.size() != 0) ? rxq[0] : 8'h00;
        e_tx_head = (txq.size() != 0) ? txq[0] : 8'h00;
    end

    always @* begin
        e_raw[0] = ((DEPTH - e_tx_n) >= tx_need(DEPTH, tx_lvl));
        e_raw[1] = (e_rx_n >= rx_need(DEPTH, {rx_lvl_hi, rx_lvl_lo}));
        e_raw[2] = ovr;
        e_raw[3] = (e_tx_n == 0);
        e_masked = e_raw & msk;
        e_irq    = (e_masked != 4'h0);
    end

endmodule

module chan_fifo_irq_test;

    localparam int CLK_NS = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_push = 1'b0, rx_pop = 1'b0, tx_push = 1'b0, tx_pop = 1'b0;
    logic [7:0] rx_wdata = 8'h00, tx_wdata = 8'h00;
    logic       rx_lvl_hi = 1'b0, rx_lvl_lo = 1'b0;
    logic [1:0] tx_lvl = 2'b00;
    logic       mask_we = 1'b0, ovr_clr = 1'b0;
    logic [3:0] mask_wdata = 4'h0;

    logic [7:0] rxd8, txd8, rxd16, txd16;
    logic [3:0] raw8, msk8, raw16, msk16;
    logic       irq8, irq16;

    logic [3:0] er8, em8, er16, em16;
    logic       ei8, ei16;
    int         ern8, etn8, ern16, etn16;
    logic [7:0] erh8, eth8, erh16, eth16;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    always #(CLK_NS / 2) clk = ~clk;

    chan_fifo_irq #(.DEPTH(8)) uut (
        .clk(clk), .rst_n(rst_n),
        .rx_push(rx_push), .rx_wdata(rx_wdata), .rx_pop(rx_pop), .rx_rdata(rxd8),
        .tx_push(tx_push), .tx_wdata(tx_wdata), .tx_pop(tx_pop), .tx_rdata(txd8),
        .rx_lvl_hi(rx_lvl_hi), .rx_lvl_lo(rx_lvl_lo), .tx_lvl(tx_lvl),
        .mask_we(mask_we), .mask_wdata(mask_wdata), .ovr_clr(ovr_clr),
        .stat_raw(raw8), .stat_masked(msk8), .irq(irq8)
    );

    chan_fifo_irq #(.DEPTH(16)) uut_d16 (
        .clk(clk), .rst_n(rst_n),
        .rx_push(rx_push), .rx_wdata(rx_wdata), .rx_pop(rx_pop), .rx_rdata(rxd16),
        .tx_push(tx_push), .tx_wdata(tx_wdata), .tx_pop(tx_pop), .tx_rdata(txd16),
        .rx_lvl_hi(rx_lvl_hi), .rx_lvl_lo(rx_lvl_lo), .tx_lvl(tx_lvl),
        .mask_we(mask_we), .mask_wdata(mask_wdata), .ovr_clr(ovr_clr),
        .stat_raw(raw16), .stat_masked(msk16), .irq(irq16)
    );

    chan_fifo_ref #(.DEPTH(8)) ref8 (
        .clk(clk), .rst_n(rst_n),
        .rx_push(rx_push), .rx_wdata(rx_wdata), .rx_pop(rx_pop),
        .tx_push(tx_push), .tx_wdata(tx_wdata), .tx_pop(tx_pop),
        .rx_lvl_hi(rx_lvl_hi), .rx_lvl_lo(rx_lvl_lo), .tx_lvl(tx_lvl),
        .mask_we(mask_we), .mask_wdata(mask_wdata), .ovr_clr(ovr_clr),
        .e_raw(er8), .e_masked(em8), .e_irq(ei8), .e_rx_n(ern8), .e_tx_n(etn8),
        .e_rx_head(erh8), .e_tx_head(eth8)
    );

    chan_fifo_ref #(.DEPTH(16)) ref16 (
        .clk(clk), .rst_n(rst_n),
        .rx_push(rx_push), .rx_wdata(rx_wdata), .rx_pop(rx_pop),
        .tx_push(tx_push), .tx_wdata(tx_wdata), .tx_pop(tx_pop),
        .rx_lvl_hi(rx_lvl_hi), .rx_lvl_lo(rx_lvl_lo), .tx_lvl(tx_lvl),
        .mask_we(mask_we), .mask_wdata(mask_wdata), .ovr_clr(ovr_clr),
        .e_raw(er16), .e_masked(em16), .e_irq(ei16), .e_rx_n(ern16), .e_tx_n(etn16),
        .e_rx_head(erh16), .e_tx_head(eth16)
    );

    task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_all();
        cmp("R4 tx ready d8",   raw8[0],  er8[0]);
        cmp("R2 rx ready d8",   raw8[1],  er8[1]);
        cmp("R7 overrun d8",    raw8[2],  er8[2]);
        cmp("R9 tx empty d8",   raw8[3],  er8[3]);
        cmp("R10 masked d8",    msk8,     em8);
        cmp("R11 irq d8",       irq8,     ei8);
        cmp("R5 tx ready d16",  raw16[0], er16[0]);
        cmp("R3 rx ready d16",  raw16[1], er16[1]);
        cmp("R7 overrun d16",   raw16[2], er16[2]);
        cmp("R9 tx empty d16",  raw16[3], er16[3]);
        cmp("R10 masked d16",   msk16,    em16);
        cmp("R11 irq d16",      irq16,    ei16);
        if (ern8 != 0)  cmp("R6 rx head d8",  rxd8,  erh8);
        if (etn8 != 0)  cmp("R6 tx head d8",  txd8,  eth8);
        if (ern16 != 0) cmp("R6 rx head d16", rxd16, erh16);
        if (etn16 != 0) cmp("R6 tx head d16", txd16, eth16);
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        check_all();
        rx_push = 1'b0; rx_pop = 1'b0; tx_push = 1'b0; tx_pop = 1'b0;
        mask_we = 1'b0; ovr_clr = 1'b0;
    endtask

    task automatic settle();
        #1;
        check_all();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_NS * 150000);
        n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values
        cmp("R1 raw d8",    raw8,  4'b1001);
        cmp("R1 masked d8", msk8,  4'b0000);
        cmp("R1 irq d8",    irq8,  1'b0);
        cmp("R1 raw d16",   raw16, 4'b1001);
        cmp("R1 irq d16",   irq16, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check_all();

        mask_we = 1'b1; mask_wdata = 4'hF;
        tick();

        // receive thresholds for every code, including overrun past full
        for (int rc = 0; rc < 4; rc++) begin
            rx_lvl_hi = rc[1]; rx_lvl_lo = rc[0];
            settle();
            for (int k = 0; k < 18; k++) begin
                rx_push = 1'b1; rx_wdata = 8'(rc * 32 + k);
                tick();
            end
            for (int k = 0; k < 18; k++) begin
                rx_pop = 1'b1;
                tick();
            end
            ovr_clr = 1'b1;
            tick();
        end

        // transmit thresholds for every code, mode changed mid-fill
        for (int tc = 0; tc < 4; tc++) begin
            tx_lvl = 2'(tc);
            settle();
            for (int k = 0; k < 17; k++) begin
                tx_push = 1'b1; tx_wdata = 8'(8'hC0 + k);
                tick();
                if (k == 7) begin
                    tx_lvl = 2'(tc + 1);
                    settle();
                    tx_lvl = 2'(tc);
                    settle();
                end
            end
            for (int k = 0; k < 17; k++) begin
                tx_pop = 1'b1;
                tick();
            end
        end

        // R8: pop on empty, then push with pop on empty
        rx_lvl_hi = 1'b0; rx_lvl_lo = 1'b0;
        settle();
        rx_pop = 1'b1;
        tick();
        cmp("R8 rx ready after empty pop d8", raw8[1], 1'b0);
        rx_pop = 1'b1; rx_push = 1'b1; rx_wdata = 8'hA5;
        tick();
        cmp("R8 byte kept d8",  rxd8,  8'hA5);
        cmp("R8 byte kept d16", rxd16, 8'hA5);
        // R12: ready visible at the edge that stored the byte
        cmp("R12 rx ready same edge d8",  raw8[1],  1'b1);
        cmp("R12 rx ready same edge d16", raw16[1], 1'b1);

        // R7: fill, then push with pop on full, then a drop against a clear
        for (int k = 0; k < 7; k++) begin
            rx_push = 1'b1; rx_wdata = 8'(8'h10 + k);
            tick();
        end
        rx_push = 1'b1; rx_pop = 1'b1; rx_wdata = 8'h77;
        tick();
        cmp("R7 no overrun on push with pop d8", raw8[2], 1'b0);
        rx_push = 1'b1; ovr_clr = 1'b1; rx_wdata = 8'h78;
        tick();
        cmp("R7 drop beats clear d8", raw8[2], 1'b1);
        tick();
        cmp("R7 overrun sticky d8", raw8[2], 1'b1);

        // R10 and R11: walk every mask value with mixed raw status
        tx_push = 1'b1; tx_wdata = 8'h3C;
        tick();
        for (int m = 0; m < 16; m++) begin
            mask_we = 1'b1; mask_wdata = 4'(m);
            tick();
            tick();
        end
        ovr_clr = 1'b1;
        tick();
        for (int k = 0; k < 18; k++) begin
            rx_pop = 1'b1; tx_pop = (k == 3);
            tick();
        end

        finish_run();
    end

endmodule